// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the serial-bus slave at the front of a small serial flash model. A host drives a mode-0 serial link: the select line is active low, the serial clock idles low, the block takes each input bit on a rising clock edge and changes its output bit on a falling clock edge. The most significant bit always comes first. All four host lines are brought into a fast system clock through synchronisers, and the block finds the edges there. The first byte of every session is an opcode. The block decodes it, gathers a three-byte address where one is needed, and answers the read-type commands from its own output shift path.

Commands that change storage or protection are not carried out here. Data bytes that arrive for a program or status write are passed on one at a time with their target address. When the select line is released at the end of a complete command, the block raises a one-cycle request to the neighbouring write and protection logic. The byte storage sits outside the block and is read through a combinational address/data port. A hold input can pause a transfer part way through. A busy input from the write engine restricts which commands are accepted.

Top module: `sflash_cmd_front`

## Requirements
- R1: While select is high, the output enable stays low, input bits are ignored and no request or data strobe is produced; after reset the output enable, request and strobe are all low.
- R2: Opcodes are compared with bit 3 treated as don't-care: 0000?110 write-enable, 0000?100 write-disable, 0000?101 status read, 0000?001 status write, 0000?011 array read, 0000?010 program, 0101?010 sector erase, 0110?010 chip erase, 0001?101 identity read; every other value is invalid.
- R3: Identity read returns 8'h1F, then 8'h60, then 8'h00 for every further byte of the session.
- R4: Status read returns `status_in` again for each byte while select stays low.
- R5: Array read takes three address bytes MSB first and uses only the low ADDR_W bits. It then streams bytes from that address, adding one after each byte and wrapping from the top address to 0.
- R6: After an invalid opcode, output stays disabled and all further input is ignored until the next falling edge of select, which restarts opcode collection.
- R7: When `busy` is high at the end of the opcode byte, every opcode except status read is treated as invalid.
- R8: A low hold input, taken while the serial clock is low, disables the output and freezes the bit position; clock edges during hold are ignored; releasing hold while the clock is low resumes at the same bit.
- R9: Write-enable, write-disable and chip erase raise `req_valid` for one cycle after select rises, with `req_op` 0, 1 and 5 respectively.
- R10: Sector erase raises a request with `req_op` 4 and `req_addr` equal to the received address once all three address bytes are in.
- R11: Program strobes each data byte with its target address; the address steps within a 256-byte page (the low 8 bits wrap, the upper bits hold). A request with `req_op` 3 follows at select release once at least one data byte arrived.
- R12: Status write strobes its single data byte and then raises a request with `req_op` 2.
- R13: No request is raised if select rises when the bits received are not a whole number of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| busy | input | 1 | Internal write cycle in progress |
| status_in | input | 8 | Status byte to report |
| mem_addr | output | ADDR_W | Storage read address |
| mem_rdata | input | 8 | Storage byte at `mem_addr` |
| req_valid | output | 1 | One-cycle command request |
| req_op | output | 3 | Request kind (codes in R9 to R12) |
| req_addr | output | ADDR_W | Address that goes with the request |
| wbyte_valid | output | 1 | One-cycle data byte strobe |
| wbyte | output | 8 | Data byte for program or status write |
| wbyte_addr | output | ADDR_W | Target address of the strobed byte |

## Verification
The bench builds the block with a 10-bit address, so that a read which wraps from 0x3FF to 0 and a program which crosses a page boundary both fit in a few bytes. The storage model is a function of the address. This keeps every streamed byte predictable without holding a large array. All 256 opcode values are swept, each followed by one extra byte. The output enable and the request count are then compared against the masked opcode table, which covers R2, R9 and R12 and the invalid codes of R6 in one pass.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR,
    OP_READ, OP_PROG, OP_SERASE, OP_CERASE, OP_RDID
  } op_e;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_DATA, PH_OUT, PH_DONE, PH_LOCK
  } phase_e;

  localparam logic [7:0] ID_FIRST  = 8'h1F;
  localparam logic [7:0] ID_SECOND = 8'h60;

  function automatic logic [2:0] req_code(op_e o);
    case (o)
      OP_WREN:   return 3'd0;
      OP_WRDI:   return 3'd1;
      OP_WRSR:   return 3'd2;
      OP_PROG:   return 3'd3;
      OP_SERASE: return 3'd4;
      OP_CERASE: return 3'd5;
      default:   return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int             N       = 4,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[gi]}};
      else        chain <= {chain[STAGES-2:0], d[gi]};
    end
    assign q[gi] = chain[STAGES-1];
  end
endmodule

// File: rtl/sfc_opdecode.sv
module sfc_opdecode
  import sfc_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    casez (code)
      8'b0000_?110: op = OP_WREN;
      8'b0000_?100: op = OP_WRDI;
      8'b0000_?101: op = OP_RDSR;
      8'b0000_?001: op = OP_WRSR;
      8'b0000_?011: op = OP_READ;
      8'b0000_?010: op = OP_PROG;
      8'b0101_?010: op = OP_SERASE;
      8'b0110_?010: op = OP_CERASE;
      8'b0001_?101: op = OP_RDID;
      default:      op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/sfc_addr.sv
module sfc_addr #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [7:0]        load_byte,
  input  logic              inc_all,
  input  logic              inc_page,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    addr_n = addr;
    if (load_en)       addr_n = ADDR_W'({addr, load_byte});
    else if (inc_all)  addr_n = addr + 1'b1;
    else if (inc_page) addr_n = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (load_en || inc_all || inc_page) addr <= addr_n;
  end
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfc_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic              busy,
  input  logic [7:0]        status_in,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              req_valid,
  output logic [2:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic              wbyte_valid,
  output logic [7:0]        wbyte,
  output logic [ADDR_W-1:0] wbyte_addr
);
  localparam int BIT_W = 3;
  localparam int ADDR_BYTES = 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  // input synchronisers and edge detection
  logic hold_q, cs_q, sck_q, si_q, sck_d, cs_d;
  sfc_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_i),
    .d({hold_n, cs_n, sck, si}),
    .q({hold_q, cs_q, sck_q, si_q})
  );
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin sck_d <= 1'b0; cs_d <= 1'b1; end
    else        begin sck_d <= sck_q; cs_d <= cs_q; end
  end

  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act;
  assign sck_rise = sck_q & ~sck_d;
  assign sck_fall = ~sck_q & sck_d;
  assign cs_fall  = ~cs_q & cs_d;
  assign cs_rise  = cs_q & ~cs_d;
  assign cs_act   = ~cs_q;

  // hold is taken only while the serial clock is low
  logic hold_act;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       hold_act <= 1'b0;
    else if (!cs_act) hold_act <= 1'b0;
    else if (!sck_q)  hold_act <= ~hold_q;
  end

  // state
  phase_e           phase, phase_n;
  op_e              op, op_n, dec_op;
  logic [BIT_W-1:0] bitcnt, bitcnt_n;
  logic [6:0]       rx, rx_n;
  logic [1:0]       abyte, abyte_n, idcnt, idcnt_n;
  logic             so_q, so_n, out_en, out_en_n, armed, armed_n;
  logic             req_v_q, req_v_n, wb_v_q, wb_v_n;
  logic [2:0]       req_op_q, req_op_n;
  logic [7:0]       wb_q, wb_n, full_byte, out_byte;
  logic [ADDR_W-1:0] addr, wb_addr_q, wb_addr_n;
  logic             a_load, a_inc, a_page;
  logic             shift_rise, byte_done, drive_fall;

  assign full_byte  = {rx, si_q};
  assign shift_rise = sck_rise & cs_act & ~hold_act & ~cs_fall & (phase != PH_LOCK);
  assign byte_done  = shift_rise & (bitcnt == 3'd7);
  assign drive_fall = sck_fall & cs_act & ~hold_act & (phase == PH_OUT);

  sfc_opdecode u_dec (.code(full_byte), .op(dec_op));

  sfc_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_i), .load_en(a_load), .load_byte(full_byte),
    .inc_all(a_inc), .inc_page(a_page), .addr(addr)
  );

  always_comb begin
    case (op)
      OP_RDSR: out_byte = status_in;
      OP_READ: out_byte = mem_rdata;
      OP_RDID: out_byte = (idcnt == 2'd0) ? ID_FIRST :
                          (idcnt == 2'd1) ? ID_SECOND : 8'h00;
      default: out_byte = 8'h00;
    endcase
  end

  always_comb begin
    phase_n = phase;   op_n = op;         bitcnt_n = bitcnt;  rx_n = rx;
    abyte_n = abyte;   idcnt_n = idcnt;   so_n = so_q;        out_en_n = out_en;
    armed_n = armed;   req_v_n = 1'b0;    req_op_n = req_op_q;
    wb_v_n = 1'b0;     wb_n = wb_q;       wb_addr_n = wb_addr_q;
    a_load = 1'b0;     a_inc = 1'b0;      a_page = 1'b0;
    if (cs_fall) begin
      phase_n = PH_CMD; bitcnt_n = '0; out_en_n = 1'b0; armed_n = 1'b0;
      abyte_n = '0;     idcnt_n = '0;
    end else if (cs_rise) begin
      req_v_n  = armed & (bitcnt == 3'd0);
      req_op_n = req_code(op);
      out_en_n = 1'b0; armed_n = 1'b0; phase_n = PH_LOCK;
    end else begin
      if (shift_rise) begin
        rx_n     = full_byte[6:0];
        bitcnt_n = bitcnt + 3'd1;
      end
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            op_n = dec_op;
            if (dec_op == OP_NONE || (busy && dec_op != OP_RDSR)) phase_n = PH_LOCK;
            else begin
              case (dec_op)
                OP_RDSR, OP_RDID:            phase_n = PH_OUT;
                OP_READ, OP_PROG, OP_SERASE: begin phase_n = PH_ADDR; abyte_n = '0; end
                OP_WRSR:                     phase_n = PH_DATA;
                default:                     begin phase_n = PH_DONE; armed_n = 1'b1; end
              endcase
            end
          end
          PH_ADDR: begin
            a_load  = 1'b1;
            abyte_n = abyte + 2'd1;
            if (abyte == 2'(ADDR_BYTES - 1)) begin
              if (op == OP_READ)      phase_n = PH_OUT;
              else if (op == OP_PROG) phase_n = PH_DATA;
              else begin phase_n = PH_DONE; armed_n = 1'b1; end
            end
          end
          PH_DATA: begin
            wb_v_n = 1'b1; wb_n = full_byte; wb_addr_n = addr; armed_n = 1'b1;
            if (op == OP_PROG) a_page = 1'b1;
            else               phase_n = PH_DONE;
          end
          PH_OUT: begin
            if (op == OP_READ) a_inc = 1'b1;
            if (op == OP_RDID && idcnt != 2'd2) idcnt_n = idcnt + 2'd1;
          end
          default: ;
        endcase
      end
      if (drive_fall) begin
        so_n     = out_byte[~bitcnt];
        out_en_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      phase <= PH_LOCK; op <= OP_NONE; bitcnt <= '0; rx <= '0; abyte <= '0;
      idcnt <= '0; so_q <= 1'b0; out_en <= 1'b0; armed <= 1'b0;
      req_v_q <= 1'b0; req_op_q <= '0; wb_v_q <= 1'b0; wb_q <= '0; wb_addr_q <= '0;
    end else begin
      phase <= phase_n; op <= op_n; bitcnt <= bitcnt_n; rx <= rx_n; abyte <= abyte_n;
      idcnt <= idcnt_n; so_q <= so_n; out_en <= out_en_n; armed <= armed_n;
      req_v_q <= req_v_n; req_op_q <= req_op_n; wb_v_q <= wb_v_n; wb_q <= wb_n;
      wb_addr_q <= wb_addr_n;
    end
  end

  assign so          = so_q;
  assign so_oe       = out_en & cs_act & ~hold_act;
  assign mem_addr    = addr;
  assign req_valid   = req_v_q;
  assign req_op      = req_op_q;
  assign req_addr    = addr;
  assign wbyte_valid = wb_v_q;
  assign wbyte       = wb_q;
  assign wbyte_addr  = wb_addr_q;

  // assertions
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_i)
    req_valid |=> !req_valid);
  assert_req_after_release_R1: assert property (@(posedge clk) disable iff (!rst_i)
    req_valid |-> $past(cs_q));
  assert_lock_quiet_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (phase == PH_LOCK) |-> !so_oe);
  assert_select_restart_R6: assert property (@(posedge clk) disable iff (!rst_i)
    cs_fall |=> (bitcnt == '0 && phase == PH_CMD));
  assert_busy_gate_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && byte_done && phase == PH_CMD && dec_op != OP_RDSR) |=> (phase == PH_LOCK));
  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (hold_act && !cs_fall) |=> $stable(bitcnt));
  assert_page_keep_R11: assert property (@(posedge clk) disable iff (!rst_i)
    (phase == PH_DATA && op == OP_PROG && byte_done)
      |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/sflash_cmd_front_test.sv
module sflash_cmd_front_test;
  localparam int AW   = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sck, cs_n, si, hold_n, busy;
  logic so, so_oe, req_valid, wbyte_valid;
  logic [7:0] status_in, mem_rdata, wbyte;
  logic [2:0] req_op;
  logic [AW-1:0] mem_addr, req_addr, wbyte_addr;

  sflash_cmd_front #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .busy(busy), .status_in(status_in),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .wbyte_valid(wbyte_valid),
    .wbyte(wbyte), .wbyte_addr(wbyte_addr)
  );

  function automatic logic [7:0] memf(input logic [AW-1:0] a);
    return 8'(a * 37 + 11);
  endfunction
  assign mem_rdata = memf(mem_addr);

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // request and data-strobe monitor
  int req_cnt = 0, wb_cnt = 0;
  logic [2:0] last_op;
  logic [AW-1:0] last_raddr;
  logic [7:0] wb_d [8];
  logic [AW-1:0] wb_a [8];
  always @(posedge clk) begin
    if (req_valid) begin req_cnt++; last_op = req_op; last_raddr = req_addr; end
    if (wbyte_valid) begin
      wb_d[wb_cnt % 8] = wbyte; wb_a[wb_cnt % 8] = wbyte_addr; wb_cnt++;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] rxb;
  logic oe_all, oe_any, held_oe;

  task automatic xfer(input logic [7:0] tx, input int nbits = 8, input bit do_hold = 0);
    oe_all = 1'b1; oe_any = 1'b0; held_oe = 1'b0; rxb = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      if (do_hold && i == 3) begin
        hold_n = 1'b0; wait_clk(HALF);
        held_oe |= so_oe;
        for (int k = 0; k < 2; k++) begin
          si = ~si; sck = 1'b1; wait_clk(HALF); held_oe |= so_oe;
          sck = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1; wait_clk(HALF);
      end
      si = tx[i]; wait_clk(HALF);
      rxb[i] = so; oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
  endtask

  task automatic cs_lo; cs_n = 1'b0; wait_clk(HALF); endtask
  task automatic cs_hi; wait_clk(HALF); cs_n = 1'b1; wait_clk(10); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int r0, w0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1;
    busy = 1'b0; status_in = 8'hA5;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);

    // R1 reset state
    check("R1 reset oe", so_oe, 0);
    check("R1 reset req", req_valid, 0);
    check("R1 reset wbyte", wbyte_valid, 0);

    // R1 idle: clocking with select high
    r0 = req_cnt; w0 = wb_cnt;
    xfer(8'h06); xfer(8'h05);
    check("R1 idle oe", oe_any, 0);
    check("R1 idle req", req_cnt - r0, 0);
    check("R1 idle wbyte", wb_cnt - w0, 0);

    // R3 / R2 identity read with bit 3 set
    cs_lo; xfer(8'h1D);
    xfer(8'h00); check("R3 id byte0", rxb, 8'h1F); check("R3 id oe", oe_all, 1);
    xfer(8'h00); check("R3 id byte1", rxb, 8'h60);
    xfer(8'h00); check("R3 id byte2", rxb, 8'h00);
    cs_hi;

    // R4 status read repeats
    cs_lo; xfer(8'h05);
    for (int b = 0; b < 3; b++) begin
      if (b == 2) status_in = 8'h5A;
      xfer(8'hFF);
      check("R4 status", rxb, (b == 2) ? 8'h5A : 8'hA5);
    end
    cs_hi;

    // R5 array read, upper address bits ignored, bit 3 of opcode set
    cs_lo; xfer(8'h0B); xfer(8'hFE); xfer(8'h01); xfer(8'h23);
    for (int b = 0; b < 3; b++) begin
      xfer(8'h00); check("R5 read", rxb, memf(AW'(10'h123 + b)));
    end
    cs_hi;

    // R5 wrap from top address
    cs_lo; xfer(8'h03); xfer(8'h00); xfer(8'h03); xfer(8'hFE);
    for (int b = 0; b < 4; b++) begin
      xfer(8'h00); check("R5 read wrap", rxb, memf(AW'(10'h3FE + b)));
    end
    cs_hi;

    // R6 invalid opcode lockout, cleared by next select
    cs_lo; xfer(8'hFF); xfer(8'h05); xfer(8'h00);
    check("R6 locked oe", oe_any, 0);
    cs_hi;
    cs_lo; xfer(8'h05); xfer(8'h00);
    check("R6 unlocked", rxb, 8'h5A);
    cs_hi;

    // R7 busy: only status read accepted
    busy = 1'b1;
    cs_lo; xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'h10); xfer(8'h00);
    check("R7 busy read oe", oe_any, 0);
    cs_hi;
    r0 = req_cnt;
    cs_lo; xfer(8'h06); cs_hi;
    check("R7 busy wren req", req_cnt - r0, 0);
    status_in = 8'hFF;
    cs_lo; xfer(8'h05); xfer(8'h00);
    check("R7 busy status", rxb, 8'hFF);
    check("R7 busy status oe", oe_all, 1);
    cs_hi;
    busy = 1'b0; status_in = 8'h3C;

    // R8 hold during output and during opcode input
    cs_lo; xfer(8'h05); xfer(8'h00, 8, 1'b1);
    check("R8 hold out data", rxb, 8'h3C);
    check("R8 hold oe off", held_oe, 0);
    cs_hi;
    cs_lo; xfer(8'h1D, 8, 1'b1); xfer(8'h00);
    check("R8 hold opcode", rxb, 8'h1F);
    cs_hi;

    // R9 simple requests
    r0 = req_cnt; cs_lo; xfer(8'h06); cs_hi;
    check("R9 wren req", req_cnt - r0, 1); check("R9 wren op", last_op, 0);
    r0 = req_cnt; cs_lo; xfer(8'h0C); cs_hi;
    check("R9 wrdi req", req_cnt - r0, 1); check("R9 wrdi op", last_op, 1);
    r0 = req_cnt; cs_lo; xfer(8'h6A); cs_hi;
    check("R9 chip erase req", req_cnt - r0, 1); check("R9 chip erase op", last_op, 5);

    // R13 partial byte
    r0 = req_cnt; cs_lo; xfer(8'h06); xfer(8'hF0, 4); cs_hi;
    check("R13 partial req", req_cnt - r0, 0);

    // R10 sector erase
    r0 = req_cnt; cs_lo; xfer(8'h52); xfer(8'h00); xfer(8'h02); xfer(8'h34); cs_hi;
    check("R10 erase req", req_cnt - r0, 1);
    check("R10 erase op", last_op, 4);
    check("R10 erase addr", last_raddr, 10'h234);

    // R11 program across the page end
    r0 = req_cnt; w0 = wb_cnt;
    cs_lo; xfer(8'h02); xfer(8'h00); xfer(8'h00); xfer(8'hFE);
    xfer(8'h11); xfer(8'h22); xfer(8'h33); cs_hi;
    check("R11 strobes", wb_cnt - w0, 3);
    for (int b = 0; b < 3; b++) begin
      check("R11 data", wb_d[(w0 + b) % 8], 8'h11 * (b + 1));
      check("R11 addr", wb_a[(w0 + b) % 8], (10'h0FE + b) & 10'h0FF);
    end
    check("R11 req", req_cnt - r0, 1); check("R11 op", last_op, 3);

    // R12 status write
    r0 = req_cnt; w0 = wb_cnt;
    cs_lo; xfer(8'h01); xfer(8'h8C); cs_hi;
    check("R12 strobe", wb_cnt - w0, 1);
    check("R12 data", wb_d[w0 % 8], 8'h8C);
    check("R12 req", req_cnt - r0, 1); check("R12 op", last_op, 2);

    // R2 / R9 / R6 sweep of every opcode followed by one byte
    status_in = 8'h81;
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc;
      bit exp_oe, exp_rq;
      cc = 8'(c);
      exp_oe = 0; exp_rq = 0;
      casez (cc)
        8'b0000_?101, 8'b0001_?101: exp_oe = 1;
        8'b0000_?110, 8'b0000_?100, 8'b0000_?001, 8'b0110_?010: exp_rq = 1;
        default: ;
      endcase
      r0 = req_cnt;
      cs_lo; xfer(cc); xfer(8'h00);
      check("R2 sweep oe", oe_all, exp_oe);
      cs_hi;
      check("R2 sweep req", req_cnt - r0, exp_rq);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule